// File: doc/BRIEF.md
# Shared cell buffer admission controller

This block performs ingress admission and occupancy accounting for a packet buffer that all ports share. Every stored packet occupies exactly one cell of a common pool. No port owns a fixed slice of that pool. The block does not hold packet data or cell indices; it keeps only the counts that decide what happens to each arriving packet.

On every arrival the block reports in the same cycle whether the packet is accepted, dropped because its egress port is congested, or dropped because the pool is full. Three counts are kept:

- a global count of cells in use;
- a per-ingress-port count, which drives a backpressure output with hysteresis;
- a per-egress-port count, which drives head-of-line drops.

When the egress side later frees a cell, it reports the packet's ingress and egress ports so that both counts can be released.

On the output side the block chooses which of four class-of-service queues is served when the egress asks for a cell. Class 3 is served first whenever it holds anything. Classes 0 to 2 share the rest of the service through weighted credits.

Top module: `sbuf_admit`

## Requirements
- R1: When `arr_valid_i` is low, `arr_res_o` is 0 in the same cycle. When it is high, `arr_res_o` is 1 for accept, 2 for a head-of-line drop and 3 for a pool-full drop, also in the same cycle.
- R2: An arrival whose egress port is within its limit is accepted while fewer than POOL_CELLS cells are in use, whatever its ingress port. The pool is not split per port.
- R3: When POOL_CELLS cells are in use, a non-head-of-line arrival gets code 3, and no count changes.
- R4: An arrival whose egress port already holds more than `hol_lim_i` cells gets code 2. This check takes precedence over code 3. `hol_drops_o` rises by one on the next clock edge, and no occupancy count changes.
- R5: A free return with `free_valid_i` releases one cell from the global count, from ingress port `free_src_i` and from egress port `free_dst_i`. An accept and a free on the same port in the same cycle leave that port's count unchanged.
- R6: `bp_o[p]` is registered and is computed from port p's ingress count after the same edge. It goes high when that count is at least `bp_hi_i`, goes low when it is at most `bp_lo_i`, and otherwise keeps its value.
- R7: When `deq_ready_i` is high and class 3 holds a cell, `deq_cos_o` is 3, and the class 0–2 credits do not change.
- R8: Otherwise the highest class among 0–2 that holds a cell and has credit is served, and its credit drops by one. If no backlogged class among 0–2 has credit, all three credits are reloaded from their weights (`wrr_w_i` bits [4c+3:4c] for class c), and the choice in that cycle uses the reloaded values.
- R9: `deq_valid_o` is high only when `deq_ready_i` is high and some class holds a cell. A grant removes one cell from the class given by `deq_cos_o`.
- R10: After reset all counts and credits are zero, `bp_o` is all zero and `hol_drops_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arr_valid_i | input | 1 | Packet arrival request |
| arr_src_i | input | PW | Ingress port of the arrival |
| arr_dst_i | input | PW | Egress port of the arrival |
| arr_cos_i | input | 2 | Class of service of the arrival |
| free_valid_i | input | 1 | Cell free return |
| free_src_i | input | PW | Ingress port of the freed packet |
| free_dst_i | input | PW | Egress port of the freed packet |
| bp_hi_i | input | CW | Backpressure assert threshold |
| bp_lo_i | input | CW | Backpressure release threshold |
| hol_lim_i | input | CW | Per-egress-port head-of-line limit |
| wrr_w_i | input | 3*WGT_W | Weights of classes 0 to 2 |
| deq_ready_i | input | 1 | Egress asks for one cell |
| arr_res_o | output | 2 | Admission result code |
| bp_o | output | NUM_PORTS | Per-port backpressure |
| hol_drops_o | output | DROP_W | Head-of-line drop counter |
| deq_valid_o | output | 1 | Dequeue grant |
| deq_cos_o | output | 2 | Class granted |

## Verification
The assertions check a set of relations on every cycle:

- no code is given without an arrival;
- no accept is given once the global count has reached the pool size;
- a grant is never given without a request;
- class 3 always wins while it holds cells;
- every edge of a backpressure output matches the threshold it crossed;
- the drop counter moves exactly with head-of-line drops.

Some behaviour only the bench's scenarios can show. These are the sequence in which weighted credits drain and reload, the hysteresis band held between the thresholds, the exact cycle on which the pool-full drop begins, and the net effect of accept and free on one port in one cycle.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int NUM_COS = 4;
  localparam int WRR_COS = 3;
  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_ACC   = 2'd1,
    RES_HOL   = 2'd2,
    RES_FULL  = 2'd3
  } adm_res_e;
endpackage

// File: rtl/sbuf_port_bp.sv
module sbuf_port_bp #(
  parameter int CW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] lo_i,
  output logic [CW-1:0] cnt_o,
  output logic          bp_o
);
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          bp_q, bp_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (inc_i && !dec_i)      cnt_nxt = cnt_q + 1'b1;
    else if (!inc_i && dec_i) cnt_nxt = cnt_q - 1'b1;
    // hysteresis on the post-edge count
    if (cnt_nxt >= hi_i)      bp_nxt = 1'b1;
    else if (cnt_nxt <= lo_i) bp_nxt = 1'b0;
    else                      bp_nxt = bp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      bp_q  <= bp_nxt;
    end
  end

  assign cnt_o = cnt_q;
  assign bp_o  = bp_q;
endmodule

// File: rtl/sbuf_pool_acct.sv
module sbuf_pool_acct
  import sbuf_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int POOL_CELLS = 8192,
  parameter int DROP_W     = 16,
  parameter int CW         = 14,
  parameter int PW         = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arr_valid_i,
  input  logic [PW-1:0]     arr_dst_i,
  input  logic              free_valid_i,
  input  logic [PW-1:0]     free_dst_i,
  input  logic [CW-1:0]     hol_lim_i,
  output adm_res_e          res_o,
  output logic [CW-1:0]     used_o,
  output logic [DROP_W-1:0] hol_drops_o
);
  localparam logic [CW-1:0] POOL_MAX = CW'(POOL_CELLS);

  logic [CW-1:0]     eg_q [NUM_PORTS];
  logic [CW-1:0]     used_q;
  logic [DROP_W-1:0] drops_q;
  logic              acc;

  always_comb begin
    if (!arr_valid_i)                     res_o = RES_NONE;
    else if (eg_q[arr_dst_i] > hol_lim_i) res_o = RES_HOL;
    else if (used_q == POOL_MAX)          res_o = RES_FULL;
    else                                  res_o = RES_ACC;
  end
  assign acc = (res_o == RES_ACC);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_eg
    logic inc, dec;
    assign inc = acc && (arr_dst_i == PW'(p));
    assign dec = free_valid_i && (free_dst_i == PW'(p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         eg_q[p] <= '0;
      else if (inc && !dec) eg_q[p] <= eg_q[p] + 1'b1;
      else if (!inc && dec) eg_q[p] <= eg_q[p] - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q  <= '0;
      drops_q <= '0;
    end else begin
      if (acc && !free_valid_i)      used_q <= used_q + 1'b1;
      else if (!acc && free_valid_i) used_q <= used_q - 1'b1;
      if (res_o == RES_HOL)          drops_q <= drops_q + 1'b1;
    end
  end

  assign used_o      = used_q;
  assign hol_drops_o = drops_q;
endmodule

// File: rtl/sbuf_cos_sched.sv
module sbuf_cos_sched
  import sbuf_pkg::*;
#(
  parameter int CW    = 14,
  parameter int WGT_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     enq_i,
  input  logic [1:0]               enq_cos_i,
  input  logic                     deq_ready_i,
  input  logic [WRR_COS*WGT_W-1:0] wgt_i,
  output logic                     deq_valid_o,
  output logic [1:0]               deq_cos_o,
  output logic                     top_backlog_o
);
  logic [CW-1:0]    cls_q  [NUM_COS];
  logic [WGT_W-1:0] cr_q   [WRR_COS];
  logic [WGT_W-1:0] cr_nxt [WRR_COS];
  logic [WGT_W-1:0] eff    [WRR_COS];
  logic [NUM_COS-1:0] backlog;
  logic               any_cr;

  always_comb begin
    for (int c = 0; c < NUM_COS; c++) backlog[c] = (cls_q[c] != '0);
    any_cr = 1'b0;
    for (int c = 0; c < WRR_COS; c++)
      if (backlog[c] && cr_q[c] != '0) any_cr = 1'b1;
    for (int c = 0; c < WRR_COS; c++)
      eff[c] = any_cr ? cr_q[c] : wgt_i[c*WGT_W +: WGT_W];
    deq_valid_o = 1'b0;
    deq_cos_o   = 2'd0;
    if (deq_ready_i) begin
      if (backlog[3]) begin
        deq_valid_o = 1'b1;
        deq_cos_o   = 2'd3;
      end else begin
        // ascending scan: highest eligible class wins
        for (int c = 0; c < WRR_COS; c++)
          if (backlog[c] && eff[c] != '0) begin
            deq_valid_o = 1'b1;
            deq_cos_o   = 2'(c);
          end
      end
    end
    for (int c = 0; c < WRR_COS; c++) begin
      cr_nxt[c] = cr_q[c];
      if (deq_valid_o && deq_cos_o != 2'd3)
        cr_nxt[c] = (deq_cos_o == 2'(c)) ? eff[c] - 1'b1 : eff[c];
    end
  end

  for (genvar c = 0; c < NUM_COS; c++) begin : g_cls
    logic inc, dec;
    assign inc = enq_i && (enq_cos_i == 2'(c));
    assign dec = deq_valid_o && (deq_cos_o == 2'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cls_q[c] <= '0;
      else if (inc && !dec) cls_q[c] <= cls_q[c] + 1'b1;
      else if (!inc && dec) cls_q[c] <= cls_q[c] - 1'b1;
    end
  end

  for (genvar c = 0; c < WRR_COS; c++) begin : g_cr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cr_q[c] <= '0;
      else         cr_q[c] <= cr_nxt[c];
    end
  end

  assign top_backlog_o = backlog[3];
endmodule

// File: rtl/sbuf_admit.sv
module sbuf_admit
  import sbuf_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int POOL_CELLS = 8192,
  parameter int WGT_W      = 4,
  parameter int DROP_W     = 16,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CW = $clog2(POOL_CELLS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arr_valid_i,
  input  logic [PW-1:0]      arr_src_i,
  input  logic [PW-1:0]      arr_dst_i,
  input  logic [1:0]         arr_cos_i,
  input  logic               free_valid_i,
  input  logic [PW-1:0]      free_src_i,
  input  logic [PW-1:0]      free_dst_i,
  input  logic [CW-1:0]      bp_hi_i,
  input  logic [CW-1:0]      bp_lo_i,
  input  logic [CW-1:0]      hol_lim_i,
  input  logic [3*WGT_W-1:0] wrr_w_i,
  input  logic               deq_ready_i,
  output logic [1:0]         arr_res_o,
  output logic [NUM_PORTS-1:0] bp_o,
  output logic [DROP_W-1:0]  hol_drops_o,
  output logic               deq_valid_o,
  output logic [1:0]         deq_cos_o
);
  adm_res_e                res;
  logic                    acc;
  logic [CW-1:0]           used_cnt;
  logic [NUM_PORTS*CW-1:0] ing_cnt;
  logic                    top_backlog;

  sbuf_pool_acct #(
    .NUM_PORTS(NUM_PORTS), .POOL_CELLS(POOL_CELLS), .DROP_W(DROP_W),
    .CW(CW), .PW(PW)
  ) u_acct (
    .clk_i, .rst_ni,
    .arr_valid_i, .arr_dst_i,
    .free_valid_i, .free_dst_i,
    .hol_lim_i,
    .res_o      (res),
    .used_o     (used_cnt),
    .hol_drops_o
  );

  assign acc       = (res == RES_ACC);
  assign arr_res_o = res;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    sbuf_port_bp #(.CW(CW)) u_bp (
      .clk_i, .rst_ni,
      .inc_i (acc && (arr_src_i == PW'(p))),
      .dec_i (free_valid_i && (free_src_i == PW'(p))),
      .hi_i  (bp_hi_i),
      .lo_i  (bp_lo_i),
      .cnt_o (ing_cnt[p*CW +: CW]),
      .bp_o  (bp_o[p])
    );
  end

  sbuf_cos_sched #(.CW(CW), .WGT_W(WGT_W)) u_sched (
    .clk_i, .rst_ni,
    .enq_i        (acc),
    .enq_cos_i    (arr_cos_i),
    .deq_ready_i,
    .wgt_i        (wrr_w_i),
    .deq_valid_o,
    .deq_cos_o,
    .top_backlog_o(top_backlog)
  );
endmodule

// File: rtl/sbuf_admit_chk.sv
module sbuf_admit_chk #(
  parameter int NUM_PORTS  = 4,
  parameter int POOL_CELLS = 8192,
  parameter int DROP_W     = 16,
  parameter int CW         = 14
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    arr_valid_i,
  input logic [1:0]              arr_res_o,
  input logic [DROP_W-1:0]       hol_drops_o,
  input logic [CW-1:0]           bp_hi_i,
  input logic [CW-1:0]           bp_lo_i,
  input logic [NUM_PORTS-1:0]    bp_o,
  input logic [NUM_PORTS*CW-1:0] ing_cnt_i,
  input logic [CW-1:0]           used_i,
  input logic                    top_backlog_i,
  input logic                    deq_ready_i,
  input logic                    deq_valid_o,
  input logic [1:0]              deq_cos_o
);
  localparam logic [CW-1:0] POOL_MAX = CW'(POOL_CELLS);

  a_r1_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arr_valid_i |-> arr_res_o == 2'd0);

  a_r3_no_accept_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_res_o == 2'd1 |-> used_i < POOL_MAX);

  a_r4_drop_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_res_o == 2'd2 |=> hol_drops_o == $past(hol_drops_o) + 1'b1);

  a_r4_drop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_res_o != 2'd2 |=> $stable(hol_drops_o));

  a_r9_grant_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_valid_o |-> deq_ready_i);

  a_r7_top_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_ready_i && top_backlog_i) |-> (deq_valid_o && deq_cos_o == 2'd3));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bp
    a_r6_bp_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bp_o[p]) |-> ing_cnt_i[p*CW +: CW] >= $past(bp_hi_i));
    a_r6_bp_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(bp_o[p]) |-> ing_cnt_i[p*CW +: CW] <= $past(bp_lo_i));
  end
endmodule

bind sbuf_admit sbuf_admit_chk #(
  .NUM_PORTS(NUM_PORTS), .POOL_CELLS(POOL_CELLS), .DROP_W(DROP_W), .CW(CW)
) u_chk (
  .clk_i, .rst_ni, .arr_valid_i, .arr_res_o, .hol_drops_o,
  .bp_hi_i, .bp_lo_i, .bp_o,
  .ing_cnt_i     (ing_cnt),
  .used_i        (used_cnt),
  .top_backlog_i (top_backlog),
  .deq_ready_i, .deq_valid_o, .deq_cos_o
);

// File: tb/sbuf_admit_bench.sv
`timescale 1ns/1ps
module sbuf_admit_bench;
  localparam int NP = 4;
  localparam int POOL = 8192;
  localparam int WW = 4;
  localparam int DW = 16;
  localparam int PW = 2;
  localparam int CW = 14;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic arr_valid_i = 0, free_valid_i = 0, deq_ready_i = 0;
  logic [PW-1:0] arr_src_i = 0, arr_dst_i = 0, free_src_i = 0, free_dst_i = 0;
  logic [1:0] arr_cos_i = 0;
  logic [CW-1:0] bp_hi_i = 0, bp_lo_i = 0, hol_lim_i = 0;
  logic [3*WW-1:0] wrr_w_i = 0;
  logic [1:0] arr_res_o, deq_cos_o;
  logic [NP-1:0] bp_o;
  logic [DW-1:0] hol_drops_o;
  logic deq_valid_o;

  always #5 clk_i = ~clk_i;

  sbuf_admit u_sbuf_admit (.*);

  int checks = 0, failures = 0;
  int ing[NP], eg[NP], cls[4], cr[3], w[3];
  int used = 0, drops = 0, hi = 0, lo = 0, hol = 0;
  bit bpm[NP];

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int h, input int l, input int hl, input int w0, input int w1, input int w2);
    hi = h; lo = l; hol = hl; w[0] = w0; w[1] = w1; w[2] = w2;
    bp_hi_i = CW'(h); bp_lo_i = CW'(l); hol_lim_i = CW'(hl);
    wrr_w_i = {WW'(w2), WW'(w1), WW'(w0)};
  endtask

  function automatic int exp_res(input bit av, input int d);
    if (!av) return 0;
    if (eg[d] > hol) return 2;
    if (used == POOL) return 3;
    return 1;
  endfunction

  function automatic bit any_credit();
    for (int c = 0; c < 3; c++) if (cls[c] > 0 && cr[c] > 0) return 1;
    return 0;
  endfunction

  function automatic int exp_deq(input bit rdy);
    int r = -1;
    bit a;
    if (!rdy) return -1;
    if (cls[3] > 0) return 3;
    a = any_credit();
    for (int c = 0; c < 3; c++) if (cls[c] > 0 && (a ? cr[c] : w[c]) > 0) r = c;
    return r;
  endfunction

  task automatic step(input bit av, input int s, input int d, input int c,
                      input bit fv, input int fs, input int fd, input bit rdy);
    int er, eq;
    bit a;
    arr_valid_i = av; arr_src_i = PW'(s); arr_dst_i = PW'(d); arr_cos_i = 2'(c);
    free_valid_i = fv; free_src_i = PW'(fs); free_dst_i = PW'(fd);
    deq_ready_i = rdy;
    #1;
    er = exp_res(av, d);
    eq = exp_deq(rdy);
    chk(int'(arr_res_o), er, er == 0 ? "R1" : er == 1 ? "R2" : er == 2 ? "R4" : "R3");
    chk(int'(deq_valid_o), eq >= 0, "R9");
    if (eq >= 0) chk(int'(deq_cos_o), eq, eq == 3 ? "R7" : "R8");
    @(posedge clk_i);
    a = any_credit();
    if (eq >= 0 && eq < 3)
      for (int k = 0; k < 3; k++) cr[k] = (a ? cr[k] : w[k]) - (k == eq ? 1 : 0);
    if (eq >= 0) cls[eq]--;
    if (er == 1) begin used++; ing[s]++; eg[d]++; cls[c]++; end
    if (er == 2) drops++;
    if (fv) begin used--; ing[fs]--; eg[fd]--; end
    for (int p = 0; p < NP; p++) begin
      if (ing[p] >= hi) bpm[p] = 1;
      else if (ing[p] <= lo) bpm[p] = 0;
    end
    @(negedge clk_i);
    for (int p = 0; p < NP; p++) chk(int'(bp_o[p]), int'(bpm[p]), "R6");
    chk(int'(hol_drops_o), drops % 65536, "R4");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int p = 0; p < NP; p++) begin ing[p] = 0; eg[p] = 0; bpm[p] = 0; end
    for (int c = 0; c < 4; c++) cls[c] = 0;
    for (int c = 0; c < 3; c++) cr[c] = 0;
    cfg(4, 1, 16383, 1, 2, 3);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk(int'(bp_o), 0, "R10");
    chk(int'(hol_drops_o), 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 1);

    // R6 hysteresis and R5 frees
    for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0, 0, 0, 0);
    chk(int'(bp_o[0]), 1, "R6");
    step(0, 0, 0, 0, 1, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0, 1, 0);
    chk(int'(bp_o[0]), 1, "R6");
    step(1, 0, 2, 1, 1, 0, 1, 0);   // net zero on port 0
    chk(int'(bp_o[0]), 1, "R5");
    step(0, 0, 0, 0, 1, 0, 2, 0);
    chk(int'(bp_o[0]), 0, "R5");

    // R4 head-of-line drops on egress port 3
    cfg(100, 50, 3, 1, 2, 3);
    for (int i = 0; i < 6; i++) step(1, 1, 3, 2, 0, 0, 0, 0);
    chk(int'(hol_drops_o), 2, "R4");

    // R8 weighted service, then R7 strict class 3
    cfg(100, 50, 16383, 1, 2, 3);
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 6; i++) step(1, 2, 0, c, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(1, 3, 0, 3, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 0, 0, 0, 1);

    // random mix
    void'($urandom(32'h5EED_0042));
    cfg(10, 4, 12, 2, 3, 4);
    for (int i = 0; i < 3000; i++) begin
      int s = $urandom_range(NP - 1), d = $urandom_range(NP - 1);
      int fs = $urandom_range(NP - 1), fd = $urandom_range(NP - 1);
      bit fv = ($urandom_range(99) < 45) && ing[fs] > 0 && eg[fd] > 0;
      step($urandom_range(99) < 60, s, d, $urandom_range(3), fv, fs, fd,
           $urandom_range(99) < 50);
    end

    // R3 fill the pool then one extra, free one, accept again
    cfg(16383, 0, 16383, 1, 1, 1);
    while (used < POOL) step(1, used % NP, (used / 4) % NP, used % 4, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0, 0);
    chk(int'(arr_res_o), 3, "R3");
    begin
      int fs = 0;
      for (int p = 0; p < NP; p++) if (ing[p] > 0) fs = p;
      step(0, 0, 0, 0, 1, fs, fs, 0);
    end
    step(1, 2, 2, 1, 0, 0, 0, 0);
    chk(used, POOL, "R2");
    finish_run();
  end
endmodule